// File: doc/BRIEF.md
# Abstract command controller

This block accepts commands for a debug module and hands them to a hart. A debugger reaches it through an APB-style register port. Through that port it writes an access-register command, reads the status, fills the shared data word and arms automatic re-execution. The block checks each command and tracks whether a command is in flight. It records the error code for the last failure and holds the first data word, which the executor can also write. When a command is valid, the block starts it on the selected hart with a one-cycle start pulse. It then waits for that hart to report done or an exception.

The block keeps a copy of the last command written while idle. Later accesses to the data word or to program-buffer words can replay that copy when their arming bits are set. This lets a debugger stream data through one address without rewriting the command. The block stores none of the program-buffer words. It only decodes their addresses to detect triggers.

Top module: `abstract_cmd_ctrl`

## Requirements
- R1: After a synchronous reset the data word, the error code, the busy flag, the arming bits and the captured command all read as zero.
- R2: The command word holds these fields: kind [31:24], size [22:20], postexec [18], transfer [17], write [16], regno [15:0]. When a supported command arrives at offset 0x08 for a halted selected hart, the block becomes busy. In the next cycle it pulses the start bit of that hart for exactly one cycle and drives the command on exec_cmd. The status word at offset 0x04 shows busy in bit 8.
- R3: When transfer is 0, a size or regno of any value is accepted and the command starts.
- R4: A command is rejected with error code 2 and does not start in any of these cases: kind is not 0; transfer is 1 and size is not 2; transfer is 1 and regno is outside 0x1000 to 0x101F.
- R5: If the selected hart is not halted when a command is requested, error code 4 is set and nothing starts.
- R6: While busy, these accesses set error code 1 (only if no error is recorded yet) and change nothing: a command write, an access to the data word, a write to the arming register, or an access to a program-buffer word.
- R7: While the error code is not zero, no command starts, neither from a command write nor from a trigger. A command written while idle is still captured and reads back at offset 0x08.
- R8: The error code is bits [2:0] of the status word. Each 1 written to those bits clears the matching error bit.
- R9: Only done or exception from the hart latched at launch ends the command. An exception also sets error code 3. Done or exception from any other hart is ignored.
- R10: Arming bit 0 of offset 0x0C enables replay on the data word. When it is set, any read or write of the data word at offset 0x00 replays the captured command once the access completes.
- R11: Arming bit 16+i enables replay on program-buffer word i, at offset 0x10+4i. Accesses to unarmed words trigger nothing.
- R12: The executor can write the data word through exec_data_we. Register reads and the exec_data0 output both return the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hartsel | input | HART_W | Index of the selected hart |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Register port write |
| paddr | input | ADDR_W | Register byte address |
| pwdata | input | 32 | Register write data |
| prdata | output | 32 | Register read data |
| hart_halted | input | NUM_HARTS | Halted status of each hart |
| exec_done | input | NUM_HARTS | Command completion from each hart |
| exec_except | input | NUM_HARTS | Command exception from each hart |
| exec_data_we | input | 1 | Executor write strobe for the data word |
| exec_data_wdata | input | 32 | Executor write value |
| exec_start | output | NUM_HARTS | One-cycle start, one bit per hart |
| exec_cmd | output | 32 | Command to execute |
| exec_data0 | output | 32 | Current data word |

## Verification
The bench targets cases that are easy to get wrong.

- A command with transfer clear but a nonsense size and regno. A design that checks those fields anyway would reject it with code 2.
- A completion strobe from a hart other than the one launched. A design that listens to the wrong hart would drop busy early.
- A data-word write while busy. If it lands, the executor's value is overwritten.
- Triggers and command writes made while an error is held. A design that ignores the held error would start the hart.
- Program-buffer words, armed and unarmed. A replay on the wrong word, or none at all, shows up directly on exec_start.

// File: rtl/acmd_pkg.sv
package acmd_pkg;

    typedef enum logic [2:0] {
        ERR_NONE       = 3'd0,
        ERR_BUSY       = 3'd1,
        ERR_UNSUP      = 3'd2,
        ERR_EXCEPT     = 3'd3,
        ERR_HALTRESUME = 3'd4
    } acmd_err_e;

    typedef struct packed {
        logic [7:0]  kind;
        logic        pad_a;
        logic [2:0]  size;
        logic        pad_b;
        logic        postexec;
        logic        transfer;
        logic        write;
        logic [15:0] regno;
    } acmd_cmd_t;

    localparam logic [2:0]  SIZE_WORD = 3'd2;
    localparam logic [15:0] GPR_FIRST = 16'h1000;
    localparam logic [15:0] GPR_LAST  = 16'h101F;

    // word indices on the register port
    localparam int W_DATA0   = 0;
    localparam int W_STATUS  = 1;
    localparam int W_CMD     = 2;
    localparam int W_AUTO    = 3;
    localparam int W_PB_BASE = 4;

    localparam int AUTO_PB_LSB   = 16;
    localparam int STAT_BUSY_BIT = 8;

    function automatic logic cmd_rejected(acmd_cmd_t c);
        logic bad;
        bad = (c.kind != 8'd0);
        // size and regno only matter when a transfer is requested
        if (c.transfer) begin
            if (c.size != SIZE_WORD) bad = 1'b1;
            if (c.regno < GPR_FIRST || c.regno > GPR_LAST) bad = 1'b1;
        end
        return bad;
    endfunction

endpackage

// File: rtl/acmd_hart_pick.sv
module acmd_hart_pick #(
    parameter int NUM_HARTS = 4,
    parameter int IDX_W     = 2
) (
    input  logic [NUM_HARTS-1:0] vec,
    input  logic [IDX_W-1:0]     idx,
    output logic                 bit_o
);
    always_comb begin
        bit_o = 1'b0;
        for (int g = 0; g < NUM_HARTS; g++) begin
            if (idx == IDX_W'(g)) bit_o = vec[g];
        end
    end
endmodule

// File: rtl/acmd_regif.sv
module acmd_regif
    import acmd_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int PB_WORDS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [31:0]         pwdata,
    input  logic                busy,
    input  logic [2:0]          cmderr,
    input  logic [31:0]         cmd_q,
    input  logic                exec_data_we,
    input  logic [31:0]         exec_data_wdata,
    output logic [31:0]         prdata,
    output logic [31:0]         data0,
    output logic                acc_data0,
    output logic                wr_status,
    output logic                wr_cmd,
    output logic                wr_auto,
    output logic [PB_WORDS-1:0] acc_pb,
    output logic                auto_data0,
    output logic [PB_WORDS-1:0] auto_pb
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]    idx;
    logic                acc;
    logic                sel_data0, sel_status, sel_cmd, sel_auto;
    logic [PB_WORDS-1:0] sel_pb;
    logic                unused_addr;

    assign idx         = paddr[ADDR_W-1:2];
    assign unused_addr = ^paddr[1:0];
    assign acc         = psel & penable;

    assign sel_data0  = (idx == IDX_W'(W_DATA0));
    assign sel_status = (idx == IDX_W'(W_STATUS));
    assign sel_cmd    = (idx == IDX_W'(W_CMD));
    assign sel_auto   = (idx == IDX_W'(W_AUTO));

    for (genvar g = 0; g < PB_WORDS; g++) begin : g_pb
        assign sel_pb[g] = (idx == IDX_W'(W_PB_BASE + g));
        assign acc_pb[g] = acc & sel_pb[g];
    end

    assign acc_data0 = acc & sel_data0;
    assign wr_status = acc & pwrite & sel_status;
    assign wr_cmd    = acc & pwrite & sel_cmd;
    assign wr_auto   = acc & pwrite & sel_auto;

    always_ff @(posedge clk) begin
        if (rst) begin
            data0      <= '0;
            auto_data0 <= 1'b0;
            auto_pb    <= '0;
        end else begin
            if (exec_data_we)
                data0 <= exec_data_wdata;
            else if (acc_data0 && pwrite && !busy)
                data0 <= pwdata;
            if (wr_auto && !busy) begin
                auto_data0 <= pwdata[0];
                auto_pb    <= pwdata[AUTO_PB_LSB +: PB_WORDS];
            end
        end
    end

    always_comb begin
        prdata = '0;
        if (sel_data0) begin
            prdata = data0;
        end else if (sel_status) begin
            prdata[2:0]           = cmderr;
            prdata[STAT_BUSY_BIT] = busy;
        end else if (sel_cmd) begin
            prdata = cmd_q;
        end else if (sel_auto) begin
            prdata[0]                        = auto_data0;
            prdata[AUTO_PB_LSB +: PB_WORDS]  = auto_pb;
        end
    end
endmodule

// File: rtl/acmd_fsm.sv
module acmd_fsm
    import acmd_pkg::*;
#(
    parameter int PB_WORDS = 2,
    parameter int HART_W   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [31:0]         pwdata,
    input  logic                acc_data0,
    input  logic                wr_status,
    input  logic                wr_cmd,
    input  logic                wr_auto,
    input  logic [PB_WORDS-1:0] acc_pb,
    input  logic                auto_data0,
    input  logic [PB_WORDS-1:0] auto_pb,
    input  logic [HART_W-1:0]   hartsel,
    input  logic                sel_halted,
    input  logic                sel_done,
    input  logic                sel_except,
    output logic                busy,
    output logic [2:0]          cmderr,
    output logic [31:0]         cmd_q,
    output logic [HART_W-1:0]   hart_q,
    output logic                start_q
);
    acmd_cmd_t cand;
    acmd_err_e new_err;
    logic      auto_hit, launch_req, fin, go, busy_hit;
    logic [2:0] err_kept;

    always_comb begin
        auto_hit   = (acc_data0 & auto_data0) | (|(acc_pb & auto_pb));
        launch_req = !busy && (wr_cmd || auto_hit);
        cand       = wr_cmd ? acmd_cmd_t'(pwdata) : acmd_cmd_t'(cmd_q);
        fin        = busy && !start_q && (sel_done || sel_except);
        busy_hit   = busy && (acc_data0 || wr_cmd || wr_auto || (|acc_pb));
        new_err    = ERR_NONE;
        go         = 1'b0;
        if (busy_hit)
            new_err = ERR_BUSY;
        else if (fin && sel_except)
            new_err = ERR_EXCEPT;
        else if (launch_req && cmderr == 3'd0) begin
            if (cmd_rejected(cand))
                new_err = ERR_UNSUP;
            else if (!sel_halted)
                new_err = ERR_HALTRESUME;
            else
                go = 1'b1;
        end
        err_kept = wr_status ? (cmderr & ~pwdata[2:0]) : cmderr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cmderr  <= 3'd0;
            cmd_q   <= '0;
            hart_q  <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= go;
            if (go) begin
                busy   <= 1'b1;
                hart_q <= hartsel;
            end else if (fin) begin
                busy <= 1'b0;
            end
            if (wr_cmd && !busy)
                cmd_q <= pwdata;
            if (err_kept == 3'd0 && new_err != ERR_NONE)
                cmderr <= new_err;
            else
                cmderr <= err_kept;
        end
    end
endmodule

// File: rtl/abstract_cmd_ctrl.sv
module abstract_cmd_ctrl
    import acmd_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int PB_WORDS  = 2,
    parameter int ADDR_W    = 8,
    localparam int HART_W   = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [HART_W-1:0]    hartsel,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    input  logic [31:0]          pwdata,
    output logic [31:0]          prdata,
    input  logic [NUM_HARTS-1:0] hart_halted,
    input  logic [NUM_HARTS-1:0] exec_done,
    input  logic [NUM_HARTS-1:0] exec_except,
    input  logic                 exec_data_we,
    input  logic [31:0]          exec_data_wdata,
    output logic [NUM_HARTS-1:0] exec_start,
    output logic [31:0]          exec_cmd,
    output logic [31:0]          exec_data0
);
    logic                busy, start_q;
    logic [2:0]          cmderr;
    logic [31:0]         cmd_q;
    logic [HART_W-1:0]   hart_q;
    logic                acc_data0, wr_status, wr_cmd, wr_auto, auto_data0;
    logic [PB_WORDS-1:0] acc_pb, auto_pb;
    logic                sel_halted, sel_done, sel_except;

    acmd_regif #(.ADDR_W(ADDR_W), .PB_WORDS(PB_WORDS)) u_regif (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .busy(busy), .cmderr(cmderr), .cmd_q(cmd_q),
        .exec_data_we(exec_data_we), .exec_data_wdata(exec_data_wdata),
        .prdata(prdata), .data0(exec_data0), .acc_data0(acc_data0),
        .wr_status(wr_status), .wr_cmd(wr_cmd), .wr_auto(wr_auto), .acc_pb(acc_pb),
        .auto_data0(auto_data0), .auto_pb(auto_pb)
    );

    acmd_hart_pick #(.NUM_HARTS(NUM_HARTS), .IDX_W(HART_W)) u_pick_halt (
        .vec(hart_halted), .idx(hartsel), .bit_o(sel_halted)
    );
    acmd_hart_pick #(.NUM_HARTS(NUM_HARTS), .IDX_W(HART_W)) u_pick_done (
        .vec(exec_done), .idx(hart_q), .bit_o(sel_done)
    );
    acmd_hart_pick #(.NUM_HARTS(NUM_HARTS), .IDX_W(HART_W)) u_pick_exc (
        .vec(exec_except), .idx(hart_q), .bit_o(sel_except)
    );

    acmd_fsm #(.PB_WORDS(PB_WORDS), .HART_W(HART_W)) u_fsm (
        .clk(clk), .rst(rst), .pwdata(pwdata), .acc_data0(acc_data0),
        .wr_status(wr_status), .wr_cmd(wr_cmd), .wr_auto(wr_auto), .acc_pb(acc_pb),
        .auto_data0(auto_data0), .auto_pb(auto_pb), .hartsel(hartsel),
        .sel_halted(sel_halted), .sel_done(sel_done), .sel_except(sel_except),
        .busy(busy), .cmderr(cmderr), .cmd_q(cmd_q), .hart_q(hart_q), .start_q(start_q)
    );

    for (genvar g = 0; g < NUM_HARTS; g++) begin : g_start
        assign exec_start[g] = start_q && (hart_q == HART_W'(g));
    end

    assign exec_cmd = cmd_q;
endmodule

// File: rtl/acmd_checker.sv
module acmd_checker #(
    parameter int NUM_HARTS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_HARTS-1:0] exec_start,
    input logic                 busy,
    input logic [2:0]           cmderr,
    input logic [31:0]          data0,
    input logic                 exec_data_we,
    input logic                 wr_cmd,
    input logic                 wr_status
);
    assert_start_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(exec_start));

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        (|exec_start) |=> !(|exec_start));

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (|exec_start) |-> busy);

    assert_busy_cmd_no_start_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_cmd) |=> !(|exec_start));

    assert_data0_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !exec_data_we) |=> $stable(data0));

    assert_err_blocks_start_R7: assert property (@(posedge clk) disable iff (rst)
        (cmderr != 3'd0 && !wr_status) |=> !(|exec_start));

    assert_err_code_range_R4: assert property (@(posedge clk) disable iff (rst)
        cmderr <= 3'd4);
endmodule

bind abstract_cmd_ctrl acmd_checker #(.NUM_HARTS(NUM_HARTS)) u_chk (
    .clk(clk), .rst(rst), .exec_start(exec_start), .busy(busy), .cmderr(cmderr),
    .data0(exec_data0), .exec_data_we(exec_data_we), .wr_cmd(wr_cmd),
    .wr_status(wr_status)
);

// File: tb/abstract_cmd_ctrl_tb.sv
module abstract_cmd_ctrl_tb;
    localparam int NH = 4;
    localparam int AW = 8;
    localparam logic [7:0] A_DATA0 = 8'h00, A_STAT = 8'h04, A_CMD = 8'h08,
                           A_AUTO = 8'h0C, A_PB0 = 8'h10, A_PB1 = 8'h14;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1;
    logic [1:0]    hartsel = 2'd1;
    logic          psel = 0, penable = 0, pwrite = 0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic [NH-1:0] hart_halted = 4'b0010, exec_done = '0, exec_except = '0;
    logic          exec_data_we = 1'b0;
    logic [31:0]   exec_data_wdata = '0;
    logic [NH-1:0] exec_start;
    logic [31:0]   exec_cmd, exec_data0;

    abstract_cmd_ctrl u_dut (
        .clk(clk), .rst(rst), .hartsel(hartsel), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .hart_halted(hart_halted), .exec_done(exec_done), .exec_except(exec_except),
        .exec_data_we(exec_data_we), .exec_data_wdata(exec_data_wdata),
        .exec_start(exec_start), .exec_cmd(exec_cmd), .exec_data0(exec_data0)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    typedef struct { logic [31:0] exp; string req; } exp_t;
    exp_t sb_q[$];
    exp_t cur;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: compare read data in the access phase
    always @(negedge clk) begin
        if (psel && penable && !pwrite && sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            check(cur.req, prdata, cur.exp);
        end
    end

    task automatic apb(input logic w, input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = w; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1;
        @(posedge clk); #1;
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        apb(1'b1, a, d);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        exp_t e;
        e.exp = exp; e.req = req;
        sb_q.push_back(e);
        apb(1'b0, a, 32'h0);
    endtask

    task automatic expect_start(input logic [NH-1:0] vec, input logic [31:0] cmd,
                                input string req);
        @(negedge clk);
        check({req, " start"}, {28'h0, exec_start}, {28'h0, vec});
        if (vec != '0) check({req, " cmd"}, exec_cmd, cmd);
    endtask

    task automatic finish_hart(input int h, input logic exc);
        @(posedge clk); #1;
        exec_done[h] = 1'b1; exec_except[h] = exc;
        @(posedge clk); #1;
        exec_done = '0; exec_except = '0;
    endtask

    task automatic exec_write(input logic [31:0] d);
        @(posedge clk); #1;
        exec_data_we = 1'b1; exec_data_wdata = d;
        @(posedge clk); #1;
        exec_data_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(A_DATA0, 32'h0, "R1 data0");
        rd(A_STAT,  32'h0, "R1 status");
        rd(A_CMD,   32'h0, "R1 command");
        rd(A_AUTO,  32'h0, "R1 arming");

        // R12 register write/read of data word
        wr(A_DATA0, 32'hA5A5_0001);
        rd(A_DATA0, 32'hA5A5_0001, "R12 data0 rw");

        // R2 launch, R6 busy collisions, R9 hart-specific completion
        wr(A_CMD, 32'h0022_1005);
        expect_start(4'b0010, 32'h0022_1005, "R2");
        rd(A_STAT, 32'h0000_0100, "R2 busy");
        wr(A_CMD, 32'h0022_1006);
        exec_write(32'h0000_1234);
        wr(A_DATA0, 32'hDEAD_BEEF);
        rd(A_STAT, 32'h0000_0101, "R6 busy error");
        check("R6 data0 untouched", exec_data0, 32'h0000_1234);
        finish_hart(0, 1'b1);
        rd(A_STAT, 32'h0000_0101, "R9 other hart ignored");
        finish_hart(1, 1'b0);
        rd(A_STAT, 32'h0000_0001, "R9 done clears busy");
        rd(A_DATA0, 32'h0000_1234, "R12 executor write");
        rd(A_CMD, 32'h0022_1005, "R6 command not recaptured");
        wr(A_STAT, 32'h7);
        rd(A_STAT, 32'h0, "R8 w1c");

        // R3 transfer clear ignores size/regno
        wr(A_CMD, 32'h0074_FFFF);
        expect_start(4'b0010, 32'h0074_FFFF, "R3");
        finish_hart(1, 1'b0);
        rd(A_STAT, 32'h0, "R3 no error");

        // R4 rejections
        wr(A_CMD, 32'h0032_1000);
        expect_start(4'b0000, 32'h0, "R4 size");
        rd(A_STAT, 32'h2, "R4 size code");
        wr(A_STAT, 32'h2);
        rd(A_STAT, 32'h0, "R8 single bit clear");
        wr(A_CMD, 32'h0022_1020);
        expect_start(4'b0000, 32'h0, "R4 regno");
        rd(A_STAT, 32'h2, "R4 regno code");
        wr(A_STAT, 32'h7);
        wr(A_CMD, 32'h0122_1000);
        expect_start(4'b0000, 32'h0, "R4 kind");
        rd(A_STAT, 32'h2, "R4 kind code");
        wr(A_STAT, 32'h7);
        wr(A_CMD, 32'h0022_101F);
        expect_start(4'b0010, 32'h0022_101F, "R4 last regno accepted");
        finish_hart(1, 1'b0);

        // R5 hart not halted
        hartsel = 2'd2;
        wr(A_CMD, 32'h0022_1000);
        expect_start(4'b0000, 32'h0, "R5");
        rd(A_STAT, 32'h4, "R5 code");
        wr(A_STAT, 32'h7);
        hartsel = 2'd1;

        // R7 held error blocks, command still captured
        wr(A_CMD, 32'h0032_1000);
        wr(A_CMD, 32'h0023_1001);
        expect_start(4'b0000, 32'h0, "R7 blocked");
        rd(A_STAT, 32'h2, "R7 error kept");
        rd(A_CMD, 32'h0023_1001, "R7 captured");
        wr(A_STAT, 32'h7);

        // R10 data word replay
        wr(A_AUTO, 32'h1);
        rd(A_AUTO, 32'h1, "R10 arming");
        rd(A_DATA0, 32'h0000_1234, "R10 read value");
        expect_start(4'b0010, 32'h0023_1001, "R10 read trigger");
        finish_hart(1, 1'b1);
        rd(A_STAT, 32'h3, "R9 exception");
        wr(A_STAT, 32'h7);
        wr(A_DATA0, 32'h0000_0055);
        expect_start(4'b0010, 32'h0023_1001, "R10 write trigger");
        check("R12 output", exec_data0, 32'h0000_0055);
        finish_hart(1, 1'b0);

        // R11 program-buffer words
        wr(A_AUTO, 32'h0002_0000);
        rd(A_AUTO, 32'h0002_0000, "R11 arming");
        wr(A_PB0, 32'h1111_1111);
        expect_start(4'b0000, 32'h0, "R11 unarmed word");
        rd(A_PB1, 32'h0, "R11 word read");
        expect_start(4'b0010, 32'h0023_1001, "R11 armed word");
        finish_hart(1, 1'b0);
        rd(A_DATA0, 32'h0000_0055, "R10 disarmed");
        expect_start(4'b0000, 32'h0, "R10 disarmed");

        // R7 held error blocks replay
        wr(A_CMD, 32'h0032_1000);
        wr(A_PB1, 32'h0);
        expect_start(4'b0000, 32'h0, "R7 replay blocked");
        rd(A_STAT, 32'h2, "R7 replay error kept");

        repeat (2) @(posedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule